// File: doc/BRIEF.md
# Line-Based Lock Detect with Hysteresis

This block turns a noisy, once-per-line "PLL is locked" indication into a steady lock-detect output. On every horizontal line a one-cycle strobe arrives, normally taken from the rising edge of the conditioned horizontal sync. At that strobe the block samples the raw lock flag and moves an internal score. A locked line raises the score by a small step and the score saturates at its maximum. An unlocked line lowers it by a larger step and the score clamps at zero. The score therefore climbs slowly and drops quickly.

The score is compared with a programmable threshold. The lock output is high only while the score is strictly above the threshold. Setting the threshold to the maximum score value keeps the output low at all times. A lower threshold suits jittery sync sources, and a higher one asks for a longer run of clean lines before lock is reported. The threshold input is captured in a register that resets to 16. The current score is also brought out as an output.

Top module: `lock_hyst`

## Requirements
- R1: While reset is high and on the first cycle after it, the score output is 0 and lock_out is 0.
- R2: On a clock edge with line_stb=1 and raw_lock=1, the score rises by INC (default 1). It ends at the maximum 255 when the sum would exceed 255.
- R3: Once the score is 255, further locked lines leave it at 255.
- R4: On a clock edge with line_stb=1 and raw_lock=0 and a score of at least DEC (default 8), the score falls by DEC.
- R5: An unlocked line that finds a score below DEC sets the score to 0. It never wraps around.
- R6: On edges with line_stb=0, the score holds its value whatever raw_lock does.
- R7: lock_out is registered. It equals (score > threshold register), both taken one cycle earlier. The threshold register captures thr_in on every clock, so a thr_in change reaches lock_out two clocks later and a score change reaches it one clock later.
- R8: While the threshold is 255, lock_out stays 0, even with the score at 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| line_stb | input | 1 | One-cycle pulse per horizontal line |
| raw_lock | input | 1 | Raw lock flag from the phase detector, sampled at line_stb |
| thr_in | input | 8 | Lock threshold; lock needs score strictly above it |
| lock_out | output | 1 | Registered lock-detect output |
| score | output | 8 | Current hysteresis score |

## Verification
The bench builds the block with its default parameters: an 8-bit score, a rise step of 1, a fall step of 8 and a threshold reset value of 16. With a rise step of 1, a few hundred locked lines are enough to reach saturation. That lets the bench exercise the top-end cases: holding at 255, the threshold-255 blocking case, and a threshold of 254 releasing lock. The fall step of 8 is large enough that two unlocked lines from a small score reach the clamp at zero.

// File: rtl/lk_pkg.sv
package lk_pkg;
  localparam int SCORE_W = 8;
  localparam logic [SCORE_W-1:0] SCORE_MAX = '1;
  typedef logic [SCORE_W-1:0] score_t;

  // saturating rise by inc
  function automatic score_t step_up(score_t s, int unsigned inc);
    logic [SCORE_W:0] sum;
    sum = {1'b0, s} + (SCORE_W+1)'(inc);
    if (sum > {1'b0, SCORE_MAX}) return SCORE_MAX;
    return sum[SCORE_W-1:0];
  endfunction

  // clamping fall by dec
  function automatic score_t step_down(score_t s, int unsigned dec);
    if (s < score_t'(dec)) return '0;
    return s - score_t'(dec);
  endfunction

  function automatic logic above(score_t s, score_t t);
    return s > t;
  endfunction
endpackage

// File: rtl/lk_score.sv
module lk_score
  import lk_pkg::*;
#(
  parameter int unsigned INC = 1,
  parameter int unsigned DEC = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   up_evt,
  input  logic   dn_evt,
  output score_t score_q
);
  score_t score_d;

  always_comb begin
    score_d = score_q;
    if (up_evt)      score_d = step_up(score_q, INC);
    else if (dn_evt) score_d = step_down(score_q, DEC);
  end

  always_ff @(posedge clk) begin
    if (rst) score_q <= '0;
    else     score_q <= score_d;
  end
endmodule

// File: rtl/lk_thresh.sv
module lk_thresh
  import lk_pkg::*;
#(
  parameter int unsigned THR_RST = 16
) (
  input  logic   clk,
  input  logic   rst,
  input  score_t thr_in,
  input  score_t score,
  output score_t thr_q,
  output logic   lock_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q  <= score_t'(THR_RST);
      lock_q <= 1'b0;
    end else begin
      thr_q  <= thr_in;
      lock_q <= above(score, thr_q);
    end
  end
endmodule

// File: rtl/lock_hyst.sv
module lock_hyst
  import lk_pkg::*;
#(
  parameter int unsigned INC     = 1,
  parameter int unsigned DEC     = 8,
  parameter int unsigned THR_RST = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_stb,
  input  logic               raw_lock,
  input  logic [SCORE_W-1:0] thr_in,
  output logic               lock_out,
  output logic [SCORE_W-1:0] score
);
  // named line events, also seen by the checker
  logic   up_evt;
  logic   dn_evt;
  score_t score_q;
  score_t thr_q;
  logic   lock_q;

  assign up_evt = line_stb &  raw_lock;
  assign dn_evt = line_stb & ~raw_lock;

  lk_score #(.INC(INC), .DEC(DEC)) u_score (
    .clk     (clk),
    .rst     (rst),
    .up_evt  (up_evt),
    .dn_evt  (dn_evt),
    .score_q (score_q)
  );

  lk_thresh #(.THR_RST(THR_RST)) u_thr (
    .clk    (clk),
    .rst    (rst),
    .thr_in (thr_in),
    .score  (score_q),
    .thr_q  (thr_q),
    .lock_q (lock_q)
  );

  assign score    = score_q;
  assign lock_out = lock_q;
endmodule

// File: rtl/lk_checker.sv
module lk_checker
  import lk_pkg::*;
#(
  parameter int unsigned INC = 1,
  parameter int unsigned DEC = 8
) (
  input logic   clk,
  input logic   rst,
  input logic   line_stb,
  input logic   up_evt,
  input logic   dn_evt,
  input score_t score,
  input score_t thr_q,
  input logic   lock_out
);
  localparam score_t UP_LIMIT = score_t'(int'(SCORE_MAX) - int'(INC));
  localparam score_t DN_STEP  = score_t'(DEC);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (score == '0 && !lock_out));

  assert_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (up_evt && score <= UP_LIMIT) |=> score == $past(score) + score_t'(INC));

  assert_saturate_R3: assert property (@(posedge clk) disable iff (rst)
    (up_evt && score > UP_LIMIT) |=> score == SCORE_MAX);

  assert_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (dn_evt && score >= DN_STEP) |=> score == $past(score) - DN_STEP);

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (dn_evt && score < DN_STEP) |=> score == '0);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !line_stb |=> $stable(score));

  assert_compare_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> lock_out == ($past(score) > $past(thr_q)));

  assert_max_thr_R8: assert property (@(posedge clk) disable iff (rst)
    (thr_q == SCORE_MAX) |=> !lock_out);
endmodule

bind lock_hyst lk_checker #(.INC(INC), .DEC(DEC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .line_stb (line_stb),
  .up_evt   (up_evt),
  .dn_evt   (dn_evt),
  .score    (score_q),
  .thr_q    (thr_q),
  .lock_out (lock_out)
);

// File: tb/tb_lock_hyst.sv
`timescale 1ns/1ps
module tb_lock_hyst;
  typedef struct {
    int    exp_score;
    bit    exp_lock;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_stb = 1'b0;
  logic       raw_lock = 1'b0;
  logic [7:0] thr_in = 8'd16;
  logic       lock_out;
  logic [7:0] score;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 0;
  item_t sb[$];
  event  sample_ev;

  // bench model state
  int m_score = 0;
  int m_thr   = 16;

  always #2.5 clk = ~clk;

  lock_hyst dut (
    .clk(clk), .rst(rst), .line_stb(line_stb), .raw_lock(raw_lock),
    .thr_in(thr_in), .lock_out(lock_out), .score(score)
  );

  function automatic int model_line(int s, bit locked);
    if (locked) return (s + 1 > 255) ? 255 : s + 1;
    return (s < 8) ? 0 : s - 8;
  endfunction

  // push expectation, wait until both registers settled, fire monitor
  task automatic expect_now(string tag);
    item_t it;
    it.exp_score = m_score;
    it.exp_lock  = (m_score > m_thr);
    it.tag       = tag;
    sb.push_back(it);
    @(posedge clk); @(posedge clk); @(negedge clk);
    ->sample_ev;
    #0.1;
  endtask

  task automatic line(bit locked, string tag);
    @(negedge clk);
    line_stb = 1'b1; raw_lock = locked;
    m_score  = model_line(m_score, locked);
    @(negedge clk);
    line_stb = 1'b0;
    raw_lock = ~locked;
    expect_now(tag);
  endtask

  task automatic set_thr(int t, string tag);
    @(negedge clk);
    thr_in = 8'(t);
    m_thr  = t;
    expect_now(tag);
  endtask

  task automatic idle_toggle(string tag);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      raw_lock = ~raw_lock;
    end
    expect_now(tag);
  endtask

  // monitor: compare popped item against ports
  initial begin
    forever begin
      item_t it;
      @(sample_ev);
      it = sb.pop_front();
      n_checks++;
      if (int'(score) != it.exp_score || lock_out != it.exp_lock) begin
        n_fail++;
        $display("FAIL %s: score=%0d lock=%0d expected score=%0d lock=%0d",
                 it.tag, score, lock_out, it.exp_score, it.exp_lock);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (4) @(negedge clk);
    n_checks++;
    if (score != 8'd0 || lock_out != 1'b0) begin
      n_fail++;
      $display("FAIL R1 in reset: score=%0d lock=%0d expected 0 0", score, lock_out);
    end
    rst = 1'b0;
    expect_now("R1 after reset");

    // R2 / R7 climb through threshold 16
    for (int i = 0; i < 20; i++) line(1'b1, "R2 R7 locked line");
    // R4 fall by 8: 20 -> 12, lock drops
    line(1'b0, "R4 unlocked line");
    // R6 no strobe, raw toggles
    idle_toggle("R6 hold without strobe");
    // R4 then R5 clamp: 12 -> 4 -> 0
    line(1'b0, "R4 fall to 4");
    line(1'b0, "R5 clamp at zero");
    line(1'b0, "R5 stays zero");
    // R7 threshold change path
    line(1'b1, "R2 rise to 1");
    set_thr(0, "R7 threshold 0 gives lock");
    set_thr(1, "R7 equal is not lock");
    // R3 saturation
    set_thr(254, "R7 threshold 254");
    for (int i = 0; i < 300; i++) line(1'b1, "R3 saturating climb");
    line(1'b1, "R3 held at 255");
    // R8 threshold 255 blocks lock
    set_thr(255, "R8 threshold 255");
    line(1'b1, "R8 still no lock");
    set_thr(254, "R7 254 releases lock");
    line(1'b0, "R4 fall from 255");
    idle_toggle("R6 hold at 247");
    finish_run();
  end
endmodule